// File: doc/BRIEF.md
# Priority-Ordered Output Switch Sequencer

This block is the digital sequencer of a single-inductor converter with several regulated outputs. It drives one main charging switch, four output switches and one freewheel switch. Every switching period starts with a charge phase on the main switch. The charge phase ends on a peak-current trip or at a fixed duty cap. The charge stored in the inductor is then handed out to the outputs in a fixed priority chain. The first three outputs each leave the chain as soon as their "above target" comparator reports. The last output keeps the inductor until the zero-current flag fires. After that the freewheel switch shorts the inductor for the rest of the period.

The block runs on one fast sequencing clock. A switching period is `PERIOD_CLKS` of these clocks long and is counted internally. All flags come from analog sensing and pass through two-flop synchronizers. Outputs 1 to 4 appear as bits 0 to 3 of `sw_out`.

A pass pointer remembers which output is next in the distribution pass. A period that ends before output 4 is reached therefore lets the next period carry on where the chain stopped. Only one switch is ever on at a time, and every hand-over between switches leaves one clock with all switches off.

Top module: `prio_switch_seq`

## Requirements
- R1: While `rst_n` is low every switch enable is 0. After reset the first discharge phase starts at output 1 (`sw_out[0]`).
- R2: Every period of `PERIOD_CLKS` clocks has the same opening. At position 0 all switches are off. At position 1 only `sw_main` is on. A synchronized `pk_trip` ends the charge phase, so with `pk_trip` held high the main switch is on for exactly one clock.
- R3: The main switch is never on for more than `floor(PERIOD_CLKS*DUTY_PCT/100)` consecutive clocks (17 at the defaults). Without a peak trip it stays on for exactly that many clocks.
- R4: Discharge phases follow the order `sw_out[0]`, `sw_out[1]`, `sw_out[2]`, `sw_out[3]`. An output among the first three ends its phase when its bit of `cmp_above` is high, and the next output in order follows.
- R5: An output whose `cmp_above` bit is high when its turn comes is skipped with no on-time. With all three bits high, the first output after the charge phase is `sw_out[3]`.
- R6: The `sw_out[3]` phase ends only on a synchronized `zc_flag`. The freewheel switch then turns on and stays on until the period ends.
- R7: The period end stops whatever phase is active. Without `zc_flag` no freewheel phase occurs, and the last output stays on through the final clock of the period.
- R8: A period that ends before `sw_out[3]` is reached makes the next discharge resume at the first output not yet served. Once `sw_out[3]` has been entered, the next pass starts again at `sw_out[0]`.
- R9: At most one of the six enables is high in any clock. Between two different enables there is always one clock with all enables low.
- R10: Each flag acts on the switches two clocks after it is sampled, through a two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sequencing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_above | input | NUM_OUT-1 | Bit k high: output k+1 is above its target |
| pk_trip | input | 1 | Inductor current has reached the peak threshold |
| zc_flag | input | 1 | Inductor current has reached zero |
| sw_main | output | 1 | Main charging switch enable |
| sw_out | output | NUM_OUT | Output switch enables, bit 0 has highest priority |
| sw_fw | output | 1 | Freewheel switch enable |

## Verification
The assertions assume that the flags are plain levels. They may change at any clock and in any combination, because the synchronizers absorb the timing. No assertion depends on a flag pattern being physically consistent. For example, a zero-current flag during the charge phase is legal and must simply be ignored.

The stimulus first holds the flags steady across whole periods, which reaches the duty cap, skipping, freewheel, continuous mode and resume. It then toggles the flags at random with modest probabilities, so that comparator edges fall mid-phase and peak trips arrive at varied points.

// File: rtl/psq_pkg.sv
package psq_pkg;

  typedef enum logic [1:0] {
    PH_GAP  = 2'd0,
    PH_MAIN = 2'd1,
    PH_OUT  = 2'd2,
    PH_FW   = 2'd3
  } phase_t;

  // Longest main on-time in sequencing clocks for a given period and duty cap.
  function automatic int unsigned cap_cycles(int unsigned period, int unsigned pct);
    return (period * pct) / 100;
  endfunction

  // First output at or after 'start' that still needs charge; 'last' has no
  // comparator and always takes charge. Supports up to 8 outputs.
  function automatic int pick_output(logic [7:0] above, int start, int last);
    int res;
    res = last;
    for (int k = 7; k >= 0; k--) begin
      if (k >= start && k < last && !above[k]) res = k;
    end
    return res;
  endfunction

endpackage

// File: rtl/psq_flag_sync.sv
module psq_flag_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/psq_period_timer.sv
module psq_period_timer #(
  parameter int PERIOD = 20,
  parameter int CAP    = 17,
  localparam int CW    = $clog2(PERIOD)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] pos,
  output logic          wrap,
  output logic          cap_hit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pos <= '0;
    else if (wrap) pos <= '0;
    else           pos <= pos + CW'(1);
  end

  assign wrap    = (pos == CW'(PERIOD - 1));
  assign cap_hit = (pos >= CW'(CAP));
endmodule

// File: rtl/psq_seq_core.sv
module psq_seq_core
  import psq_pkg::*;
#(
  parameter int NUM_OUT = 4,
  localparam int IW     = $clog2(NUM_OUT),
  localparam int LAST   = NUM_OUT - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrap,
  input  logic              cap_hit,
  input  logic              s_pk,
  input  logic              s_zc,
  input  logic [NUM_OUT-2:0] s_above,
  output phase_t            phase,
  output logic [IW-1:0]     idx
);
  phase_t        pend, nxt_phase, nxt_pend;
  logic [IW-1:0] ptr, nxt_idx, nxt_ptr;
  logic [7:0]    above8;

  always_comb begin
    above8 = '0;
    above8[NUM_OUT-2:0] = s_above;
  end

  always_comb begin
    nxt_phase = phase;
    nxt_pend  = pend;
    nxt_idx   = idx;
    nxt_ptr   = ptr;
    if (wrap) begin
      nxt_phase = PH_GAP;
      nxt_pend  = PH_MAIN;
    end else begin
      unique case (phase)
        PH_GAP: begin
          nxt_phase = pend;
          if (pend == PH_OUT) begin
            nxt_idx = IW'(pick_output(above8, int'(ptr), LAST));
            nxt_ptr = (nxt_idx == IW'(LAST)) ? '0 : nxt_idx;
          end
        end
        PH_MAIN: begin
          if (s_pk || cap_hit) begin
            nxt_phase = PH_GAP;
            nxt_pend  = PH_OUT;
          end
        end
        PH_OUT: begin
          if (idx == IW'(LAST)) begin
            if (s_zc) begin
              nxt_phase = PH_GAP;
              nxt_pend  = PH_FW;
            end
          end else if (above8[idx]) begin
            nxt_phase = PH_GAP;
            nxt_pend  = PH_OUT;
            nxt_ptr   = idx + IW'(1);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_GAP;
      pend  <= PH_MAIN;
      idx   <= '0;
      ptr   <= '0;
    end else begin
      phase <= nxt_phase;
      pend  <= nxt_pend;
      idx   <= nxt_idx;
      ptr   <= nxt_ptr;
    end
  end
endmodule

// File: rtl/prio_switch_seq.sv
module prio_switch_seq
  import psq_pkg::*;
#(
  parameter int NUM_OUT     = 4,
  parameter int PERIOD_CLKS = 20,
  parameter int DUTY_PCT    = 85,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_OUT-2:0] cmp_above,
  input  logic               pk_trip,
  input  logic               zc_flag,
  output logic               sw_main,
  output logic [NUM_OUT-1:0] sw_out,
  output logic               sw_fw
);
  localparam int CAP_CLKS = int'(cap_cycles(PERIOD_CLKS, DUTY_PCT));
  localparam int CW       = $clog2(PERIOD_CLKS);
  localparam int IW       = $clog2(NUM_OUT);
  localparam int FW_BITS  = NUM_OUT + 1;

  logic [FW_BITS-1:0] flags_raw, flags_s;
  logic [CW-1:0]      cyc_pos;
  logic               ev_wrap, ev_cap;
  phase_t             phase;
  logic [IW-1:0]      idx;

  assign flags_raw = {pk_trip, zc_flag, cmp_above};

  psq_flag_sync #(.W(FW_BITS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(flags_raw), .q(flags_s)
  );

  psq_period_timer #(.PERIOD(PERIOD_CLKS), .CAP(CAP_CLKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .pos(cyc_pos), .wrap(ev_wrap), .cap_hit(ev_cap)
  );

  psq_seq_core #(.NUM_OUT(NUM_OUT)) u_core (
    .clk(clk), .rst_n(rst_n), .wrap(ev_wrap), .cap_hit(ev_cap),
    .s_pk(flags_s[FW_BITS-1]), .s_zc(flags_s[FW_BITS-2]),
    .s_above(flags_s[NUM_OUT-2:0]), .phase(phase), .idx(idx)
  );

  assign sw_main = (phase == PH_MAIN);
  assign sw_fw   = (phase == PH_FW);

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    assign sw_out[g] = (phase == PH_OUT) && (idx == IW'(g));
  end
endmodule

// File: rtl/psq_chk.sv
module psq_chk #(
  parameter int NUM_OUT = 4,
  parameter int CAP     = 17,
  parameter int CW      = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sw_main,
  input logic [NUM_OUT-1:0] sw_out,
  input logic               sw_fw,
  input logic               ev_wrap,
  input logic               ev_cap,
  input logic [CW-1:0]      cyc_pos
);
  logic [NUM_OUT+1:0] en;
  logic [15:0]        main_run;

  assign en = {sw_fw, sw_out, sw_main};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       main_run <= '0;
    else if (sw_main) main_run <= main_run + 16'd1;
    else              main_run <= '0;
  end

  // R9
  one_switch_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(en));

  // R9
  break_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(en) != '0) && (en != $past(en))) |-> (en == '0));

  // R3
  duty_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    main_run <= 16'(CAP));

  // R3
  cap_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_main && ev_cap) |=> !sw_main);

  // R2
  charge_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_main) |-> (cyc_pos == CW'(1)));

  // R7
  period_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wrap |=> (en == '0));

  // R6
  fw_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_fw) |-> $past(sw_out[NUM_OUT-1], 2));

  // R6
  fw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_fw && !ev_wrap) |=> sw_fw);
endmodule

bind prio_switch_seq psq_chk #(.NUM_OUT(NUM_OUT), .CAP(CAP_CLKS), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_main(sw_main), .sw_out(sw_out), .sw_fw(sw_fw),
  .ev_wrap(ev_wrap), .ev_cap(ev_cap), .cyc_pos(cyc_pos)
);

// File: tb/test_prio_switch_seq.sv
module test_prio_switch_seq;
  localparam int N    = 4;
  localparam int P    = 20;
  localparam int PCT  = 85;
  localparam int CAPC = (P * PCT) / 100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-2:0] cmp = '0;
  logic pk = 1'b0, zc = 1'b0;
  logic sw_main, sw_fw;
  logic [N-1:0] sw_out;

  prio_switch_seq #(.NUM_OUT(N), .PERIOD_CLKS(P), .DUTY_PCT(PCT)) i_prio_switch_seq (
    .clk(clk), .rst_n(rst_n), .cmp_above(cmp), .pk_trip(pk), .zc_flag(zc),
    .sw_main(sw_main), .sw_out(sw_out), .sw_fw(sw_fw)
  );

  always #2 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0, mon_en = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // Reference: mode 0 idle, 1 charging, 2 serving output m_idx, 3 freewheel
  int m_cnt, m_mode, m_after, m_idx, m_ptr;
  logic [N-2:0] c1, c2;
  logic p1, p2, z1, z2;

  function automatic int first_open(int from, logic [N-2:0] above);
    for (int k = from; k < N - 1; k++) if (!above[k]) return k;
    return N - 1;
  endfunction

  function automatic logic [N+1:0] exp_vec(int mode, int ix);
    logic [N+1:0] v = '0;
    if (mode == 1) v[0] = 1'b1;
    else if (mode == 2) v[ix+1] = 1'b1;
    else if (mode == 3) v[N+1] = 1'b1;
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin : ref_model
    int nm, na, ni, np;
    if (!rst_n) begin
      m_cnt = 0; m_mode = 0; m_after = 1; m_idx = 0; m_ptr = 0;
      c1 = '0; c2 = '0; p1 = 0; p2 = 0; z1 = 0; z2 = 0;
    end else begin
      nm = m_mode; na = m_after; ni = m_idx; np = m_ptr;
      if (m_cnt == P - 1) begin
        nm = 0; na = 1;
      end else begin
        case (m_mode)
          0: begin
            nm = m_after;
            if (m_after == 2) begin
              ni = first_open(m_ptr, c2);
              np = (ni == N - 1) ? 0 : ni;
            end
          end
          1: if (p2 || m_cnt >= CAPC) begin nm = 0; na = 2; end
          2: begin
            if (m_idx == N - 1) begin
              if (z2) begin nm = 0; na = 3; end
            end else if (c2[m_idx]) begin
              nm = 0; na = 2; np = m_idx + 1;
            end
          end
          default: ;
        endcase
      end
      m_mode = nm; m_after = na; m_idx = ni; m_ptr = np;
      c2 = c1; c1 = cmp; p2 = p1; p1 = pk; z2 = z1; z1 = zc;
      m_cnt = (m_cnt == P - 1) ? 0 : m_cnt + 1;
    end
  end

  // Per-period observations
  int cur_main, cur_first, last_main, last_first, periods = 0;
  bit cur_fw, last_fw;
  logic [15:0] cur_seq, last_seq;
  logic [N+1:0] cur_tail, last_tail, prev_vec = '0;

  always @(negedge clk) begin : monitor
    logic [N+1:0] vec;
    string req;
    vec = {sw_fw, sw_out, sw_main};
    if (mon_en) begin
      if (m_cnt == 0) begin
        last_main = cur_main; last_first = cur_first; last_fw = cur_fw;
        last_seq = cur_seq; last_tail = cur_tail;
        cur_main = 0; cur_first = -1; cur_fw = 0; cur_seq = '0; cur_tail = '0;
        periods++;
      end
      if (sw_main) cur_main++;
      if (sw_fw) cur_fw = 1;
      for (int k = 0; k < N; k++) begin
        if (sw_out[k]) begin
          if (cur_first < 0) cur_first = k;
          if (!prev_vec[k+1]) cur_seq = {cur_seq[11:0], 4'(k + 1)};
        end
      end
      if (m_cnt == P - 1) cur_tail = vec;
      case (m_mode)
        1: req = "R2";
        2: req = (m_idx == N - 1) ? "R6" : "R4";
        3: req = "R6";
        default: req = "R9";
      endcase
      chk(req, 32'(vec), 32'(exp_vec(m_mode, m_idx)), "switch vector vs reference (R10 timing)");
      chk("R9", 32'($countones(vec) <= 1), 32'd1, "at most one enable");
      chk("R9", 32'((prev_vec != '0) && (vec != '0) && (vec != prev_vec)), 32'd0, "gap between switches");
    end
    prev_vec = vec;
  end

  task automatic align;
    do @(negedge clk); while (m_cnt != 0);
  endtask

  task automatic hold(logic p, logic [N-2:0] c, logic z, int n);
    align();
    pk = p; cmp = c; zc = z;
    repeat (n * P) @(negedge clk);
    #1;
  endtask

  initial begin : watchdog
    #(4 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog run did not finish act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stimulus
    void'($urandom(32'h5eed_1234));
    cur_main = 0; cur_first = -1; cur_fw = 0; cur_seq = '0; cur_tail = '0;
    repeat (3) @(negedge clk);
    chk("R1", 32'({sw_fw, sw_out, sw_main}), 32'd0, "enables in reset");
    mon_en = 1;
    @(negedge clk) rst_n = 1'b1;

    // R1: pointer starts at output 1
    hold(1'b1, 3'b000, 1'b0, 2);
    chk("R1", 32'(last_first), 32'd0, "first output after reset");
    // R2: trip held high ends charge after one clock
    chk("R2", 32'(last_main), 32'd1, "main on-time with trip");
    // R3: no trip, main limited by duty cap
    hold(1'b0, 3'b000, 1'b0, 2);
    chk("R3", 32'(last_main), 32'(CAPC), "main on-time at cap");
    // R5: all above target -> straight to last output
    hold(1'b1, 3'b111, 1'b0, 2);
    chk("R5", 32'(last_first), 32'(N - 1), "first output with all skipped");
    chk("R5", 32'(last_seq), 32'h4, "only last output served");
    // R7: no zero current -> no freewheel, last output to the end
    chk("R7", 32'(last_fw), 32'd0, "freewheel in continuous mode");
    chk("R7", 32'(last_tail), 32'(exp_vec(2, N - 1)), "last clock of period");
    // R6: zero current -> freewheel to period end
    hold(1'b1, 3'b111, 1'b1, 2);
    chk("R6", 32'(last_fw), 32'd1, "freewheel after zero current");
    chk("R6", 32'(last_tail), 32'(exp_vec(3, 0)), "freewheel at period end");
    // R8: after last output served, pass restarts at output 1
    hold(1'b1, 3'b000, 1'b0, 2);
    chk("R8", 32'(last_first), 32'd0, "restart after full pass");
    // R8: interrupted at output 2 resumes there
    hold(1'b1, 3'b001, 1'b0, 1);
    hold(1'b1, 3'b000, 1'b0, 1);
    chk("R8", 32'(last_first), 32'd1, "resume at unserved output");
    // R4: comparator mid-phase hands over to next in order
    hold(1'b1, 3'b111, 1'b0, 1);
    cmp = 3'b000;
    repeat (6) @(negedge clk);
    cmp = 3'b001;
    repeat (P - 6) @(negedge clk);
    #1;
    chk("R4", 32'(last_seq), 32'h12, "order output 1 then 2");

    // Constrained random: flags toggle at random points
    for (int cyc = 0; cyc < 400 * P; cyc++) begin
      @(negedge clk);
      pk = ($urandom % 7) == 0;
      zc = ($urandom % 4) == 0;
      for (int k = 0; k < N - 1; k++) if (($urandom % 8) == 0) cmp[k] = ~cmp[k];
    end
    @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule